// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers up to 64 level-sensitive device interrupt lines into one raw request vector and fans that vector out to four processors. Every processor owns a 64-bit enable mask. A processor's interrupt output is high whenever its mask and the raw vector share at least one set bit. Software programs the masks through a plain register port. It can also read the raw vector and, for each processor, the masked request view that produced that processor's interrupt.

The input lines are synchronous to the block clock and are registered into the raw vector on every cycle. A separate input from a cascaded legacy interrupt controller is merged into raw bit 55. The masks, the raw vector and the per-processor outputs are all cleared by reset, so nothing is delivered until software opens a mask. Register reads are combinational from the address. Register writes take effect at the clock edge where the write strobe is high. The register port carries no stream data, so it has no valid/ready handshake: a write strobe is accepted every cycle it is high, and read data follows the read address in the same cycle.

Top module: `irq_fanout_router`

## Requirements
- R1: The raw vector register holds, from one clock edge to the next, the levels that the input lines had at the earlier edge. A line that goes high or low changes its raw bit one cycle later.
- R2: The legacy controller input sets raw bit 55 while it is high, ORed with input line 55.
- R3: Output `cpu_irq_o[n]` is high exactly when the bitwise AND of mask n and the raw vector is nonzero.
- R4: A write to a mask address replaces that mask alone. The addresses are 0x200 for CPU0, 0x240 for CPU1, 0x600 for CPU2 and 0x640 for CPU3. A read at the same address returns the stored mask.
- R5: A read of a view address returns mask n AND raw. The view addresses are 0x280 for CPU0, 0x2C0 for CPU1, 0x680 for CPU2 and 0x6C0 for CPU3.
- R6: A read of address 0x300 returns the raw vector.
- R7: A write to any view address or to the raw address changes no mask and no output.
- R8: During and right after reset, all masks, the raw vector and all four outputs are zero.
- R9: A read of any address outside the map returns zero. A write to such an address changes no mask.
- R10: A new mask value already drives the output in the cycle that follows the write edge. Before that edge, the output still reflects the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq_i | input | 64 | Level-sensitive device interrupt lines |
| legacy_irq_i | input | 1 | Cascaded legacy controller request, merged into bit 55 |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_addr | input | 12 | Register write byte address |
| csr_wr_data | input | 64 | Register write data |
| csr_rd_addr | input | 12 | Register read byte address |
| csr_rd_data | output | 64 | Register read data, combinational from the read address |
| cpu_irq_o | output | 4 | Per-processor interrupt request, one bit per CPU |

## Verification
The routing function is driven with a table of input and mask pairs. The pairs cover disjoint masks, masks that overlap only at the top bit, alternating-bit patterns against complementary masks, and a single bit that all four masks hit. Together they show whether each output uses its own mask, whether the AND covers all 64 bit positions, and whether one CPU's mask leaks into another CPU's output. For every row, each view address and the raw address are read back, which ties what software sees to what the outputs do. Directed cases check the legacy merge on bit 55, writes to the read-only and unmapped addresses, and the one-cycle timing of input and mask changes.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int ADDR_W   = 12;
  localparam int MAX_CPUS = 4;

  typedef logic [ADDR_W-1:0] csr_addr_t;

  localparam csr_addr_t RAW_ADDR   = 12'h300;
  localparam csr_addr_t VIEW_DELTA = 12'h080;

  // Mask locations: the two low CPUs share one page, the two high ones another.
  function automatic csr_addr_t mask_addr(input int n);
    if (n < 2) mask_addr = csr_addr_t'(12'h200 + n * 12'h040);
    else       mask_addr = csr_addr_t'(12'h600 + (n - 2) * 12'h040);
  endfunction

  function automatic csr_addr_t view_addr(input int n);
    view_addr = mask_addr(n) + VIEW_DELTA;
  endfunction
endpackage

// File: rtl/irqr_raw_latch.sv
module irqr_raw_latch #(
  parameter int LINES      = 64,
  parameter int LEGACY_BIT = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] dev_irq_i,
  input  logic             legacy_irq_i,
  output logic [LINES-1:0] raw_q
);
  logic [LINES-1:0] legacy_vec;
  logic [LINES-1:0] raw_d;

  always_comb begin
    legacy_vec             = '0;
    legacy_vec[LEGACY_BIT] = legacy_irq_i;
    raw_d                  = dev_irq_i | legacy_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end
endmodule

// File: rtl/irqr_mask_slot.sv
module irqr_mask_slot
  import irqr_pkg::*;
#(
  parameter int LINES = 64,
  parameter int SLOT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  csr_addr_t        wr_addr,
  input  logic [LINES-1:0] wr_data,
  input  logic [LINES-1:0] raw_q,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] view,
  output logic             irq
);
  localparam csr_addr_t MY_ADDR = mask_addr(SLOT);

  logic hit;
  assign hit = wr_en && (wr_addr == MY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '0;
    else if (hit) mask_q <= wr_data;
  end

  assign view = mask_q & raw_q;
  assign irq  = |view;
endmodule

// File: rtl/irqr_read_mux.sv
module irqr_read_mux
  import irqr_pkg::*;
#(
  parameter int LINES = 64,
  parameter int CPUS  = 4
) (
  input  csr_addr_t             rd_addr,
  input  logic [CPUS*LINES-1:0] mask_flat,
  input  logic [CPUS*LINES-1:0] view_flat,
  input  logic [LINES-1:0]      raw_q,
  output logic [LINES-1:0]      rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == RAW_ADDR) rd_data = raw_q;
    for (int n = 0; n < CPUS; n++) begin
      if (rd_addr == mask_addr(n)) rd_data = mask_flat[n*LINES +: LINES];
      if (rd_addr == view_addr(n)) rd_data = view_flat[n*LINES +: LINES];
    end
  end
endmodule

// File: rtl/irq_fanout_router.sv
module irq_fanout_router
  import irqr_pkg::*;
#(
  parameter int LINES      = 64,
  parameter int CPUS       = 4,
  parameter int LEGACY_BIT = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] dev_irq_i,
  input  logic             legacy_irq_i,
  input  logic             csr_wr_en,
  input  logic [11:0]      csr_wr_addr,
  input  logic [LINES-1:0] csr_wr_data,
  input  logic [11:0]      csr_rd_addr,
  output logic [LINES-1:0] csr_rd_data,
  output logic [CPUS-1:0]  cpu_irq_o
);
  localparam int FLAT_W = CPUS * LINES;

  logic [LINES-1:0]  raw_q;
  logic [FLAT_W-1:0] mask_flat;
  logic [FLAT_W-1:0] view_flat;

  irqr_raw_latch #(.LINES(LINES), .LEGACY_BIT(LEGACY_BIT)) u_raw (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_irq_i    (dev_irq_i),
    .legacy_irq_i (legacy_irq_i),
    .raw_q        (raw_q)
  );

  for (genvar n = 0; n < CPUS; n++) begin : g_slot
    irqr_mask_slot #(.LINES(LINES), .SLOT(n)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (csr_wr_en),
      .wr_addr (csr_wr_addr),
      .wr_data (csr_wr_data),
      .raw_q   (raw_q),
      .mask_q  (mask_flat[n*LINES +: LINES]),
      .view    (view_flat[n*LINES +: LINES]),
      .irq     (cpu_irq_o[n])
    );
  end

  irqr_read_mux #(.LINES(LINES), .CPUS(CPUS)) u_rd (
    .rd_addr   (csr_rd_addr),
    .mask_flat (mask_flat),
    .view_flat (view_flat),
    .raw_q     (raw_q),
    .rd_data   (csr_rd_data)
  );
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
  import irqr_pkg::*;
#(
  parameter int LINES      = 64,
  parameter int CPUS       = 4,
  parameter int LEGACY_BIT = 55
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LINES-1:0]      dev_irq_i,
  input logic                  legacy_irq_i,
  input logic                  csr_wr_en,
  input logic [11:0]           csr_wr_addr,
  input logic [LINES-1:0]      csr_wr_data,
  input logic [11:0]           csr_rd_addr,
  input logic [LINES-1:0]      csr_rd_data,
  input logic [CPUS-1:0]       cpu_irq_o,
  input logic [CPUS*LINES-1:0] mask_flat,
  input logic [LINES-1:0]      raw_q
);
  logic             past_ok;
  logic [LINES-1:0] merged_in;
  logic             ro_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    merged_in             = dev_irq_i;
    merged_in[LEGACY_BIT] = dev_irq_i[LEGACY_BIT] | legacy_irq_i;
    ro_write              = csr_wr_en && (csr_wr_addr == RAW_ADDR);
    for (int n = 0; n < CPUS; n++)
      if (csr_wr_en && csr_wr_addr == view_addr(n)) ro_write = 1'b1;
  end

  // R1 R2
  raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> raw_q == $past(merged_in));

  // R7
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write |=> $stable(mask_flat));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_flat == '0 && cpu_irq_o == '0));

  // R6
  raw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_addr == RAW_ADDR |-> csr_rd_data == raw_q);

  for (genvar n = 0; n < CPUS; n++) begin : g_chk
    // R4
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && csr_wr_addr == mask_addr(n)) |=>
        mask_flat[n*LINES +: LINES] == $past(csr_wr_data));
    // R3 R5
    view_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rd_addr == view_addr(n) |-> (|csr_rd_data) == cpu_irq_o[n]);
  end
endmodule

bind irq_fanout_router irqr_checker #(
  .LINES(LINES), .CPUS(CPUS), .LEGACY_BIT(LEGACY_BIT)
) u_irqr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .dev_irq_i    (dev_irq_i),
  .legacy_irq_i (legacy_irq_i),
  .csr_wr_en    (csr_wr_en),
  .csr_wr_addr  (csr_wr_addr),
  .csr_wr_data  (csr_wr_data),
  .csr_rd_addr  (csr_rd_addr),
  .csr_rd_data  (csr_rd_data),
  .cpu_irq_o    (cpu_irq_o),
  .mask_flat    (mask_flat),
  .raw_q        (raw_q)
);

// File: tb/irq_fanout_router_bench.sv
`timescale 1ns/1ps
module irq_fanout_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dev_irq_i = '0;
  logic        legacy_irq_i = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [11:0] csr_wr_addr = '0;
  logic [63:0] csr_wr_data = '0;
  logic [11:0] csr_rd_addr = '0;
  logic [63:0] csr_rd_data;
  logic [3:0]  cpu_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_fanout_router u_irq_fanout_router (
    .clk(clk), .rst_n(rst_n), .dev_irq_i(dev_irq_i), .legacy_irq_i(legacy_irq_i),
    .csr_wr_en(csr_wr_en), .csr_wr_addr(csr_wr_addr), .csr_wr_data(csr_wr_data),
    .csr_rd_addr(csr_rd_addr), .csr_rd_data(csr_rd_data), .cpu_irq_o(cpu_irq_o)
  );

  localparam logic [11:0] MADDR [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
  localparam logic [11:0] VADDR [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};
  localparam logic [11:0] RADDR     = 12'h300;

  typedef struct packed {
    logic [63:0] din;
    logic [63:0] m0, m1, m2, m3;
    logic [3:0]  exp_irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h0, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, 4'b0000},
    '{64'h1, 64'h1, 64'h0, 64'h0, 64'h0, 4'b0001},
    '{64'h8000_0000_0000_0000, 64'h0, 64'h1, 64'h0, 64'h8000_0000_0000_0000, 4'b1000},
    '{{64{1'b1}}, 64'h0, 64'h10, 64'h0, 64'h0, 4'b0010},
    '{64'hF0, 64'h0F, 64'hF0, 64'h100, 64'h80, 4'b1010},
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA,
      {64{1'b1}}, 64'h5555_5555_5555_5555, 4'b0110},
    '{64'h0001_0000_0000_0000, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, 4'b1111},
    '{64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 4'b0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_addr = a; csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    csr_rd_addr = a;
    #1;
    d = csr_rd_data;
  endtask

  task automatic drive_in(input logic [63:0] v);
    @(negedge clk);
    dev_irq_i = v;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [63:0] m [4];
    repeat (3) @(negedge clk);
    // R8: state while reset is held
    check("R8 irq in reset", {60'h0, cpu_irq_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R8 irq after reset", {60'h0, cpu_irq_o}, 64'h0);
    for (int n = 0; n < 4; n++) begin
      rd(MADDR[n], d);
      check("R8 mask after reset", d, 64'h0);
    end
    rd(RADDR, d);
    check("R8 raw after reset", d, 64'h0);

    // Table walk: R1 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      m[0] = VECS[i].m0; m[1] = VECS[i].m1; m[2] = VECS[i].m2; m[3] = VECS[i].m3;
      for (int n = 0; n < 4; n++) wr(MADDR[n], m[n]);
      drive_in(VECS[i].din);
      check("R3 irq vector", {60'h0, cpu_irq_o}, {60'h0, VECS[i].exp_irq});
      rd(RADDR, d);
      check("R6 raw read", d, VECS[i].din);
      for (int n = 0; n < 4; n++) begin
        rd(MADDR[n], d);
        check("R4 mask readback", d, m[n]);
        rd(VADDR[n], d);
        check("R5 view read", d, m[n] & VECS[i].din);
      end
    end

    // R4: writing one mask leaves the others
    wr(MADDR[0], 64'h0); wr(MADDR[1], 64'h0); wr(MADDR[2], 64'h0); wr(MADDR[3], 64'h0);
    wr(MADDR[2], 64'h1234);
    rd(MADDR[0], d); check("R4 other mask untouched", d, 64'h0);
    rd(MADDR[3], d); check("R4 other mask untouched", d, 64'h0);
    rd(MADDR[2], d); check("R4 target mask", d, 64'h1234);

    // R2: legacy input lands on bit 55
    wr(MADDR[2], 64'h0080_0000_0000_0000);
    @(negedge clk); legacy_irq_i = 1'b1; dev_irq_i = '0;
    @(negedge clk); #1;
    rd(RADDR, d);
    check("R2 legacy raw bit", d, 64'h0080_0000_0000_0000);
    check("R2 legacy routed", {60'h0, cpu_irq_o}, 64'h4);
    @(negedge clk); legacy_irq_i = 1'b0;
    @(negedge clk); #1;
    check("R2 legacy released", {60'h0, cpu_irq_o}, 64'h0);

    // R1: one-cycle input latency
    wr(MADDR[1], 64'h2);
    @(negedge clk); dev_irq_i = 64'h2; #1;
    check("R1 before edge", {60'h0, cpu_irq_o}, 64'h0);
    @(negedge clk); #1;
    check("R1 after edge", {60'h0, cpu_irq_o}, 64'h2);
    @(negedge clk); dev_irq_i = 64'h0;
    @(negedge clk); #1;
    check("R1 line low clears", {60'h0, cpu_irq_o}, 64'h0);

    // R10: mask change timing
    dev_irq_i = 64'h4;
    @(negedge clk); #1;
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_addr = MADDR[0]; csr_wr_data = 64'h4; #1;
    check("R10 old mask before edge", {60'h0, cpu_irq_o}, 64'h0);
    @(negedge clk); csr_wr_en = 1'b0; #1;
    check("R10 new mask after edge", {60'h0, cpu_irq_o}, 64'h1);

    // R7: writes to read-only addresses ignored
    for (int n = 0; n < 4; n++) wr(VADDR[n], {64{1'b1}});
    wr(RADDR, {64{1'b1}});
    rd(MADDR[0], d); check("R7 mask0 kept", d, 64'h4);
    rd(MADDR[1], d); check("R7 mask1 kept", d, 64'h2);
    rd(MADDR[3], d); check("R7 mask3 kept", d, 64'h0);
    rd(RADDR, d);    check("R7 raw kept", d, 64'h4);
    check("R7 irq kept", {60'h0, cpu_irq_o}, 64'h1);

    // R9: unmapped addresses
    rd(12'h100, d); check("R9 unmapped read", d, 64'h0);
    rd(12'h204, d); check("R9 unmapped read", d, 64'h0);
    wr(12'h208, {64{1'b1}});
    wr(12'h740, {64{1'b1}});
    rd(MADDR[0], d); check("R9 mask0 after stray write", d, 64'h4);
    rd(MADDR[3], d); check("R9 mask3 after stray write", d, 64'h0);
    check("R9 irq after stray write", {60'h0, cpu_irq_o}, 64'h1);

    // R8: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0; #1;
    check("R8 irq under reset", {60'h0, cpu_irq_o}, 64'h0);
    @(negedge clk); rst_n = 1'b1; #1;
    rd(MADDR[0], d); check("R8 mask cleared", d, 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule